// File: doc/BRIEF.md
# CSR Transition Coverage Monitor

This block watches a stream of committed-instruction records on the coverage side of a processor fuzzing flow. Each record carries a mnemonic identifier (the operation class, with no operands) and a snapshot of six monitored control and status registers, always in this order: machine status, machine trap cause, supervisor trap cause, exception delegation, floating-point rounding mode, floating-point exception flags. The monitor compares each accepted record with the previous one in the same test. When monitored state changes, it builds a transition key from the mnemonic and the old and new register values.

Changes are split into two groups, each with its own associative table. A change in the rounding mode or the flags goes to the floating-point group. A change in any of the other four registers goes to the privileged group. Before the privileged group is considered, a per-bit ignore mask removes machine-status bits that software routinely writes. A key that is not already in its table is stored, counted and marks the current test as interesting. The tables persist across tests and are emptied only by a session clear.

Top module: `csr_trans_monitor`

## Requirements
- R1: The first record accepted after reset, `test_start` or `sess_clr` only loads the previous-state register and never produces a transition.
- R2: A record whose monitored values all equal those of the previous record produces no transition and leaves `new_count`, `interesting` and both tables unchanged.
- R3: A transition key absent from its table is inserted, sets `interesting`, and adds one to `new_count` (two when both groups insert from the same record). `interesting` is 1 exactly when `new_count` is non-zero. `new_count` saturates at its maximum.
- R4: A key already present in its table (same mnemonic, same old values, same new values) changes no output and no table.
- R5: The key includes the mnemonic. The same register change caused by a different mnemonic is a distinct new key.
- R6: A change in rounding mode or flags goes only to the floating-point table. A change in the other four registers goes only to the privileged table. One record can add to both. A full floating-point table never blocks a privileged insert.
- R7: A privileged transition is counted only if the trap-cause, delegation or status registers differ in a bit where `mstatus_ignore_mask` is 0. A change confined to masked status bits is dropped.
- R8: A one-cycle `test_start` pulse clears `interesting` and `new_count` and restarts change detection, but keeps both tables. A transition seen in an earlier test is therefore not new.
- R9: Reset and `sess_clr` empty both tables and clear `overflow`, `interesting` and `new_count`.
- R10: Each table holds DEPTH keys, and its full flag is 1 when all entries are used. A new key offered to a full table is dropped, sets the sticky `overflow` flag, and neither counts nor sets `interesting`.
- R11: After a record is accepted, `rec_ready` is 0 for exactly one cycle while the lookup and insert run. `new_count` changes only on the edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sess_clr | input | 1 | Start of session: empties the tables and clears all status |
| test_start | input | 1 | Start of test: clears the per-test status and restarts change detection |
| rec_valid | input | 1 | Commit record valid |
| rec_ready | output | 1 | Monitor can accept a record |
| rec_mnem | input | MNEM_W | Mnemonic identifier of the committed instruction |
| rec_stat | input | CSR_W | Machine status value |
| rec_mtrap | input | CSR_W | Machine trap cause value |
| rec_strap | input | CSR_W | Supervisor trap cause value |
| rec_deleg | input | CSR_W | Exception delegation value |
| rec_fp_rnd | input | RND_W | Floating-point rounding mode |
| rec_fp_flags | input | FLG_W | Floating-point exception flags |
| mstatus_ignore_mask | input | CSR_W | 1 in a bit makes changes of that status bit uninteresting |
| interesting | output | 1 | Current test produced at least one new transition |
| new_count | output | CNT_W | Number of new transitions in the current test (saturating) |
| overflow | output | 1 | Sticky: a new key was dropped because its table was full |
| fp_full | output | 1 | Floating-point table full |
| priv_full | output | 1 | Privileged table full |

## Verification
The assertions check on every cycle the properties that hold at the ports: the one-cycle ready gap after each accept, `new_count` moving only at the end of a lookup cycle and by at most two, `interesting` agreeing with a non-zero count, `overflow` staying set until a session clear, and the clearing done by the session and test controls. Only the bench's scenarios can show which keys count as new. That covers duplicates, distinct mnemonics for the same change, the ignore mask, the split between the two tables, table persistence across a test start, and drop-on-full. The bench checks these against its own model of both tables over a sweep of mnemonics and flag values.

// File: rtl/csrmon_pkg.sv
package csrmon_pkg;
   typedef struct packed {
      logic fp;
      logic priv;
   } grp_flags_t;
endpackage

// File: rtl/csrmon_detect.sv
module csrmon_detect #(
   parameter int CSR_W = 32,
   parameter int RND_W = 3,
   parameter int FLG_W = 5
) (
   input  logic [CSR_W-1:0] p_stat,
   input  logic [CSR_W-1:0] p_mtrap,
   input  logic [CSR_W-1:0] p_strap,
   input  logic [CSR_W-1:0] p_deleg,
   input  logic [RND_W-1:0] p_rnd,
   input  logic [FLG_W-1:0] p_flg,
   input  logic [CSR_W-1:0] c_stat,
   input  logic [CSR_W-1:0] c_mtrap,
   input  logic [CSR_W-1:0] c_strap,
   input  logic [CSR_W-1:0] c_deleg,
   input  logic [RND_W-1:0] c_rnd,
   input  logic [FLG_W-1:0] c_flg,
   input  logic [CSR_W-1:0] ign_mask,
   output csrmon_pkg::grp_flags_t chg
);
   logic [CSR_W-1:0] stat_diff;

   assign stat_diff = (p_stat ^ c_stat) & ~ign_mask;
   assign chg.fp    = (p_rnd != c_rnd) || (p_flg != c_flg);
   assign chg.priv  = (|stat_diff) || (p_mtrap != c_mtrap) ||
                      (p_strap != c_strap) || (p_deleg != c_deleg);
endmodule

// File: rtl/csrmon_cam.sv
module csrmon_cam #(
   parameter int KEY_W = 16,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             look,
   input  logic [KEY_W-1:0] key,
   output logic             ins,
   output logic             drop,
   output logic             full
);
   localparam int FILL_W = $clog2(DEPTH + 1);

   logic [KEY_W-1:0]  ent [DEPTH];
   logic [DEPTH-1:0]  vld;
   logic [DEPTH-1:0]  hitv;
   logic [FILL_W-1:0] fill;

   if (DEPTH < 1) begin : g_bad_depth
      $error("csrmon_cam: DEPTH must be at least 1");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign hitv[i] = vld[i] && (ent[i] == key);

      always_ff @(posedge clk) begin
         if (ins && (fill == FILL_W'(i))) ent[i] <= key;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            vld[i] <= 1'b0;
         else if (clr)                          vld[i] <= 1'b0;
         else if (ins && (fill == FILL_W'(i)))  vld[i] <= 1'b1;
      end
   end

   assign full = (fill == FILL_W'(DEPTH));
   assign ins  = look && !(|hitv) && !full;
   assign drop = look && !(|hitv) && full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   fill <= '0;
      else if (clr) fill <= '0;
      else if (ins) fill <= fill + 1'b1;
   end
endmodule

// File: rtl/csr_trans_monitor.sv
module csr_trans_monitor #(
   parameter int MNEM_W = 8,
   parameter int CSR_W  = 32,
   parameter int RND_W  = 3,
   parameter int FLG_W  = 5,
   parameter int DEPTH  = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sess_clr,
   input  logic              test_start,
   input  logic              rec_valid,
   output logic              rec_ready,
   input  logic [MNEM_W-1:0] rec_mnem,
   input  logic [CSR_W-1:0]  rec_stat,
   input  logic [CSR_W-1:0]  rec_mtrap,
   input  logic [CSR_W-1:0]  rec_strap,
   input  logic [CSR_W-1:0]  rec_deleg,
   input  logic [RND_W-1:0]  rec_fp_rnd,
   input  logic [FLG_W-1:0]  rec_fp_flags,
   input  logic [CSR_W-1:0]  mstatus_ignore_mask,
   output logic              interesting,
   output logic [CNT_W-1:0]  new_count,
   output logic              overflow,
   output logic              fp_full,
   output logic              priv_full
);
   import csrmon_pkg::*;

   localparam int FP_W   = RND_W + FLG_W;
   localparam int PR_W   = 4 * CSR_W;
   localparam int FPK_W  = MNEM_W + 2 * FP_W;
   localparam int PRK_W  = MNEM_W + 2 * PR_W;
   localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

   if (CNT_W < 2) begin : g_bad_cnt
      $error("csr_trans_monitor: CNT_W must be at least 2");
   end
   if (MNEM_W < 1 || CSR_W < 1) begin : g_bad_w
      $error("csr_trans_monitor: widths must be positive");
   end

   logic [PR_W-1:0]  prev_pr, cur_pr;
   logic [FP_W-1:0]  prev_fp, cur_fp;
   logic             prev_ok, busy, accept;
   grp_flags_t       chg, look_q;
   logic [FPK_W-1:0] fp_key_q;
   logic [PRK_W-1:0] pr_key_q;
   logic             fp_ins, fp_drop, pr_ins, pr_drop;
   logic [CNT_W:0]   cnt_sum;

   assign cur_pr    = {rec_stat, rec_mtrap, rec_strap, rec_deleg};
   assign cur_fp    = {rec_fp_rnd, rec_fp_flags};
   assign rec_ready = !busy;
   assign accept    = rec_valid && rec_ready;

   csrmon_detect #(.CSR_W(CSR_W), .RND_W(RND_W), .FLG_W(FLG_W)) u_detect (
      .p_stat  (prev_pr[4*CSR_W-1:3*CSR_W]),
      .p_mtrap (prev_pr[3*CSR_W-1:2*CSR_W]),
      .p_strap (prev_pr[2*CSR_W-1:CSR_W]),
      .p_deleg (prev_pr[CSR_W-1:0]),
      .p_rnd   (prev_fp[FP_W-1:FLG_W]),
      .p_flg   (prev_fp[FLG_W-1:0]),
      .c_stat  (rec_stat),
      .c_mtrap (rec_mtrap),
      .c_strap (rec_strap),
      .c_deleg (rec_deleg),
      .c_rnd   (rec_fp_rnd),
      .c_flg   (rec_fp_flags),
      .ign_mask(mstatus_ignore_mask),
      .chg     (chg)
   );

   csrmon_cam #(.KEY_W(FPK_W), .DEPTH(DEPTH)) u_fp_tab (
      .clk(clk), .rst_n(rst_n), .clr(sess_clr),
      .look(busy && look_q.fp), .key(fp_key_q),
      .ins(fp_ins), .drop(fp_drop), .full(fp_full)
   );

   csrmon_cam #(.KEY_W(PRK_W), .DEPTH(DEPTH)) u_pr_tab (
      .clk(clk), .rst_n(rst_n), .clr(sess_clr),
      .look(busy && look_q.priv), .key(pr_key_q),
      .ins(pr_ins), .drop(pr_drop), .full(priv_full)
   );

   always_comb begin
      cnt_sum = {1'b0, new_count} + (CNT_W+1)'(fp_ins) + (CNT_W+1)'(pr_ins);
      if (cnt_sum > CNT_MAX) cnt_sum = CNT_MAX;
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         prev_pr  <= cur_pr;
         prev_fp  <= cur_fp;
         fp_key_q <= {rec_mnem, prev_fp, cur_fp};
         pr_key_q <= {rec_mnem, prev_pr, cur_pr};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ok     <= 1'b0;
         busy        <= 1'b0;
         look_q      <= '0;
         interesting <= 1'b0;
         new_count   <= '0;
         overflow    <= 1'b0;
      end else if (sess_clr || test_start) begin
         prev_ok     <= 1'b0;
         busy        <= 1'b0;
         look_q      <= '0;
         interesting <= 1'b0;
         new_count   <= '0;
         if (sess_clr) overflow <= 1'b0;
      end else if (busy) begin
         busy      <= 1'b0;
         new_count <= cnt_sum[CNT_W-1:0];
         if (fp_ins || pr_ins)   interesting <= 1'b1;
         if (fp_drop || pr_drop) overflow    <= 1'b1;
      end else if (accept) begin
         busy        <= 1'b1;
         prev_ok     <= 1'b1;
         look_q.fp   <= prev_ok && chg.fp;
         look_q.priv <= prev_ok && chg.priv;
      end
   end
endmodule

// File: rtl/csrmon_chk.sv
module csrmon_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sess_clr,
   input logic             test_start,
   input logic             rec_valid,
   input logic             rec_ready,
   input logic             interesting,
   input logic [CNT_W-1:0] new_count,
   input logic             overflow
);
   // R11
   ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_ready && !sess_clr && !test_start) |=> !rec_ready);
   // R11
   busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rec_ready && !sess_clr && !test_start) |=> rec_ready);
   // R11
   count_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sess_clr && !test_start && rec_ready) |=> (new_count == $past(new_count)));
   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sess_clr && !test_start) |=>
         ({1'b0, new_count} >= {1'b0, $past(new_count)}) &&
         ({1'b0, new_count} <= {1'b0, $past(new_count)} + 2));
   // R3
   int_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      interesting == (new_count != '0));
   // R10
   overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !sess_clr) |=> overflow);
   // R9
   sess_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sess_clr |=> (!overflow && !interesting && new_count == '0));
   // R8
   test_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      test_start |=> (!interesting && new_count == '0));
endmodule

bind csr_trans_monitor csrmon_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sess_clr(sess_clr), .test_start(test_start),
   .rec_valid(rec_valid), .rec_ready(rec_ready), .interesting(interesting),
   .new_count(new_count), .overflow(overflow)
);

// File: tb/csr_trans_monitor_bench.sv
module csr_trans_monitor_bench;
   localparam int MW = 4, CW = 8, RW = 3, FW = 5, DP = 4, NW = 4;

   logic clk = 1'b0, rst_n = 1'b0, sess_clr = 1'b0, test_start = 1'b0;
   logic rec_valid = 1'b0;
   logic rec_ready;
   logic [MW-1:0] rec_mnem = '0;
   logic [CW-1:0] rec_stat = '0, rec_mtrap = '0, rec_strap = '0, rec_deleg = '0;
   logic [RW-1:0] rec_fp_rnd = '0;
   logic [FW-1:0] rec_fp_flags = '0;
   logic [CW-1:0] mask = 8'h0F;
   logic interesting, overflow, fp_full, priv_full;
   logic [NW-1:0] new_count;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench model
   logic [127:0] m_fp [DP];
   logic [127:0] m_pr [DP];
   int  n_fp = 0, n_pr = 0, e_cnt = 0;
   bit  e_int = 0, e_ovf = 0, have_prev = 0;
   logic [CW-1:0] p_st, p_mt, p_sc, p_dl;
   logic [RW-1:0] p_rn;
   logic [FW-1:0] p_fl;

   always #2 clk = ~clk;

   csr_trans_monitor #(.MNEM_W(MW), .CSR_W(CW), .RND_W(RW), .FLG_W(FW),
                       .DEPTH(DP), .CNT_W(NW)) u_csr_trans_monitor (
      .clk(clk), .rst_n(rst_n), .sess_clr(sess_clr), .test_start(test_start),
      .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_mnem(rec_mnem),
      .rec_stat(rec_stat), .rec_mtrap(rec_mtrap), .rec_strap(rec_strap),
      .rec_deleg(rec_deleg), .rec_fp_rnd(rec_fp_rnd), .rec_fp_flags(rec_fp_flags),
      .mstatus_ignore_mask(mask), .interesting(interesting), .new_count(new_count),
      .overflow(overflow), .fp_full(fp_full), .priv_full(priv_full)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_ins(bit fp, logic [127:0] k);
      bit found = 0;
      int n = fp ? n_fp : n_pr;
      for (int i = 0; i < n; i++)
         if ((fp ? m_fp[i] : m_pr[i]) == k) found = 1;
      if (!found) begin
         if (n < DP) begin
            if (fp) begin m_fp[n_fp] = k; n_fp++; end
            else    begin m_pr[n_pr] = k; n_pr++; end
            if (e_cnt < 15) e_cnt++;
            e_int = 1;
         end else e_ovf = 1;
      end
   endtask

   task automatic model_step(logic [MW-1:0] mn, logic [CW-1:0] st, logic [CW-1:0] mt,
                             logic [CW-1:0] sc, logic [CW-1:0] dl,
                             logic [RW-1:0] rn, logic [FW-1:0] fl);
      if (have_prev) begin
         if (rn != p_rn || fl != p_fl)
            model_ins(1, 128'({mn, p_rn, p_fl, rn, fl}));
         if ((((st ^ p_st) & ~mask) != 0) || mt != p_mt || sc != p_sc || dl != p_dl)
            model_ins(0, 128'({mn, p_st, p_mt, p_sc, p_dl, st, mt, sc, dl}));
      end
      have_prev = 1;
      p_st = st; p_mt = mt; p_sc = sc; p_dl = dl; p_rn = rn; p_fl = fl;
   endtask

   task automatic compare_all(string req);
      check({req, " new_count"}, int'(new_count), e_cnt);
      check({req, " interesting"}, int'(interesting), int'(e_int));
      check({req, " overflow"}, int'(overflow), int'(e_ovf));
      check({req, " fp_full"}, int'(fp_full), int'(n_fp == DP));
      check({req, " priv_full"}, int'(priv_full), int'(n_pr == DP));
   endtask

   task automatic send(logic [MW-1:0] mn, logic [CW-1:0] st, logic [CW-1:0] mt,
                       logic [RW-1:0] rn, logic [FW-1:0] fl);
      @(negedge clk);
      rec_valid = 1'b1; rec_mnem = mn; rec_stat = st; rec_mtrap = mt;
      rec_strap = '0; rec_deleg = '0; rec_fp_rnd = rn; rec_fp_flags = fl;
      check("R11 ready before accept", int'(rec_ready), 1);
      @(posedge clk); #1;
      check("R11 ready low after accept", int'(rec_ready), 0);
      @(negedge clk);
      rec_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      model_step(mn, st, mt, '0, '0, rn, fl);
      compare_all("R3 model");
   endtask

   task automatic pulse_test_start();
      @(negedge clk); test_start = 1'b1;
      @(negedge clk); test_start = 1'b0;
      have_prev = 0; e_cnt = 0; e_int = 0;
   endtask

   task automatic pulse_sess_clr();
      @(negedge clk); sess_clr = 1'b1;
      @(negedge clk); sess_clr = 1'b0;
      have_prev = 0; e_cnt = 0; e_int = 0; e_ovf = 0; n_fp = 0; n_pr = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 reset new_count", int'(new_count), 0);
      check("R9 reset overflow", int'(overflow), 0);
      check("R9 reset fp_full", int'(fp_full), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 ready after reset", int'(rec_ready), 1);

      send(4'd1, 8'h00, 8'h00, 3'd0, 5'd0);
      check("R1 first record no transition", int'(new_count), 0);
      send(4'd1, 8'h00, 8'h00, 3'd0, 5'd0);
      check("R2 unchanged tuple", int'(new_count), 0);
      send(4'd1, 8'h00, 8'h00, 3'd0, 5'd1);
      check("R3 new fp key", int'(new_count), 1);
      check("R3 interesting", int'(interesting), 1);
      send(4'd2, 8'h00, 8'h00, 3'd0, 5'd0);
      check("R3 reverse change new", int'(new_count), 2);
      send(4'd1, 8'h00, 8'h00, 3'd0, 5'd1);
      check("R4 duplicate key", int'(new_count), 2);
      send(4'd3, 8'h00, 8'h00, 3'd0, 5'd0);
      check("R5 other mnemonic same change", int'(new_count), 3);
      send(4'd1, 8'h05, 8'h00, 3'd0, 5'd0);
      check("R7 masked status bits dropped", int'(new_count), 3);
      send(4'd1, 8'h15, 8'h00, 3'd0, 5'd0);
      check("R7 unmasked status bit counted", int'(new_count), 4);
      send(4'd4, 8'h15, 8'h01, 3'd0, 5'd2);
      check("R6 both groups insert", int'(new_count), 6);
      check("R6 fp table full", int'(fp_full), 1);
      check("R6 priv table not full", int'(priv_full), 0);
      send(4'd5, 8'h15, 8'h01, 3'd0, 5'd3);
      check("R10 drop on full", int'(new_count), 6);
      check("R10 overflow set", int'(overflow), 1);
      send(4'd5, 8'h15, 8'h02, 3'd0, 5'd3);
      check("R6 priv insert despite fp full", int'(new_count), 7);
      check("R10 overflow sticky", int'(overflow), 1);

      pulse_test_start();
      check("R8 count cleared", int'(new_count), 0);
      check("R8 interesting cleared", int'(interesting), 0);
      check("R8 table kept", int'(fp_full), 1);
      send(4'd6, 8'h15, 8'h01, 3'd0, 5'd3);
      check("R1 first after test_start", int'(new_count), 0);
      send(4'd5, 8'h15, 8'h02, 3'd0, 5'd3);
      check("R8 old transition not new", int'(new_count), 0);

      pulse_sess_clr();
      check("R9 overflow cleared", int'(overflow), 0);
      check("R9 fp table emptied", int'(fp_full), 0);
      check("R9 priv table emptied", int'(priv_full), 0);
      send(4'd6, 8'h15, 8'h01, 3'd0, 5'd3);
      send(4'd5, 8'h15, 8'h02, 3'd0, 5'd3);
      check("R9 key new after clear", int'(new_count), 1);

      // sweep over mnemonics and flag values, checked by the model
      for (int s = 0; s < 2; s++) begin
         pulse_sess_clr();
         for (int m = 0; m < 4; m++) begin
            pulse_test_start();
            for (int f = 0; f < 8; f++)
               send(MW'(m), 8'h10 | CW'(f & 3), CW'((f >> s) & 1), RW'(f >> 1), FW'(f & 1));
         end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule